// File: doc/BRIEF.md
# Interleaved DRAM Line-Fill Controller

This block services a cache miss by fetching one four-word line from a small simulated main memory. It reproduces the cycle timing of three memory organizations. A request presents a line index. The controller spends one cycle on the address and waits out the array access latency. It then hands the words back on a response bus, each beat qualified by a valid strobe. A done strobe marks the final beat.

A static two-bit mode input selects the organization:

- **Sequential:** a one-word-wide memory that performs a separate access for every word.
- **Wide:** a four-word-wide memory that fetches and returns the whole line at once.
- **Interleaved:** four banks start together, and their words are streamed out one per cycle.

The mode is latched when the request is accepted. The backing store is a reset-loaded register array held in four banks, where bank k holds word k of every line. This fixed content lets the returned data be predicted exactly.

Top module: `dram_linefill`

## Requirements
- R1: While reset is held and in the cycle after its release, req_ready is 1, and rsp_valid, rsp_done and every bit of rsp_data are 0; a reset in the middle of a fill abandons it and returns to this state.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the fill completes, so a request raised during a fill is not served. The fill in progress returns the data of the line latched at acceptance, even if req_addr changes later.
- R3: Sequential mode (mode 00) returns 4 beats. If the accepting edge is edge 0, the beats occupy the cycles ending at edges 17, 33, 49 and 65, so the line takes 1 + 4×15 + 4×1 = 65 cycles.
- R4: Wide mode (mode 01) returns exactly one beat, in the cycle ending at edge 17 (1 + 15 + 1). That beat carries word k of the line in rsp_data bits [k*32 +: 32] for k = 0..3.
- R5: Interleaved mode (mode 10) returns 4 beats in the cycles ending at edges 17, 18, 19 and 20 (1 + 15 + 4×1).
- R6: Word w of line L holds ((L*4 + w) * 0x01010101) XOR 0xA5A50000, truncated to 32 bits. In sequential and interleaved modes, words arrive in ascending order from word 0, in bits [31:0], with all upper bits 0.
- R7: rsp_done is 1 for exactly one cycle per fill, together with the last beat, and never without rsp_valid.
- R8: Mode 11 behaves as sequential mode. The mode is sampled only at acceptance, so changing the mode input during a fill does not alter that fill's timing or data.
- R9: req_ready returns to 1 in the cycle right after the done beat, so a request held waiting is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Memory organization: 00 sequential, 01 wide, 10 interleaved, 11 sequential |
| req_valid | input | 1 | Line fill request |
| req_addr | input | 4 | Line index of the request |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | Response beat present |
| rsp_data | output | 128 | Beat data, four 32-bit lanes |
| rsp_done | output | 1 | Last beat of the line |

## Verification
In sequential mode, the cycle that transfers word k is the same cycle that launches the access of bank k+1. Merging these two actions is what keeps the beat spacing at 16 cycles rather than 17. Sequential fills in both modes 00 and 11 provoke this overlap. The bench judges it by the exact edge numbers of every beat, 17, 33, 49 and 65, and by the data in each beat.

A second same-cycle pairing occurs at the end of a fill: the done beat ends, and a waiting request is admitted one edge later. A chained fill checks this pairing.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

   typedef enum logic [1:0] {
      MODE_SEQ  = 2'b00,
      MODE_WIDE = 2'b01,
      MODE_ILV  = 2'b10
   } dlf_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ADDR = 2'b01,
      ST_WAIT = 2'b10,
      ST_XFER = 2'b11
   } dlf_state_e;

   function automatic dlf_mode_e dlf_decode_mode(input logic [1:0] m);
      case (m)
         2'b01:   return MODE_WIDE;
         2'b10:   return MODE_ILV;
         default: return MODE_SEQ;
      endcase
   endfunction

   function automatic logic [31:0] dlf_seed(input int unsigned n);
      return (n * 32'h0101_0101) ^ 32'hA5A5_0000;
   endfunction

endpackage

// File: rtl/dlf_bank.sv
module dlf_bank #(
   parameter int DW         = 32,
   parameter int LINES      = 16,
   parameter int WORDS      = 4,
   parameter int BANK_ID    = 0,
   parameter int ACCESS_CYC = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [$clog2(LINES)-1:0] line,
   output logic                     rdy,
   output logic [DW-1:0]            data
);
   localparam int AW = $clog2(LINES);
   localparam int CW = $clog2(ACCESS_CYC + 1);

   logic [DW-1:0] store [LINES];
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic [AW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++)
            store[l] <= DW'(dlf_pkg::dlf_seed(l * WORDS + BANK_ID));
         busy_q <= 1'b0;
         cnt_q  <= '0;
         idx_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(ACCESS_CYC - 1);
         idx_q  <= line;
      end else if (busy_q && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign rdy  = busy_q && (cnt_q == '0);
   assign data = store[idx_q];

   // R2
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !start) |=> (rdy && $stable(data)));

endmodule

// File: rtl/dlf_sequencer.sv
module dlf_sequencer
   import dlf_pkg::*;
#(
   parameter int LINES = 16,
   parameter int WORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode,
   input  logic                     req_valid,
   input  logic [$clog2(LINES)-1:0] req_addr,
   input  logic [WORDS-1:0]         bank_rdy,
   output logic                     req_ready,
   output logic [WORDS-1:0]         bank_start,
   output logic [$clog2(LINES)-1:0] line_q,
   output logic [$clog2(WORDS)-1:0] widx_q,
   output dlf_mode_e                mode_q,
   output logic                     rsp_valid,
   output logic                     rsp_done
);
   localparam int WIW = $clog2(WORDS);
   localparam logic [WIW-1:0] LAST_IDX = WIW'(WORDS - 1);

   dlf_state_e state_q;
   logic       last_beat;
   logic       access_done;

   assign last_beat   = (mode_q == MODE_WIDE) || (widx_q == LAST_IDX);
   assign access_done = (mode_q == MODE_SEQ) ? bank_rdy[widx_q] : &bank_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         widx_q  <= '0;
         line_q  <= '0;
         mode_q  <= MODE_SEQ;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               state_q <= ST_ADDR;
               mode_q  <= dlf_decode_mode(mode);
               line_q  <= req_addr;
               widx_q  <= '0;
            end
            ST_ADDR: state_q <= ST_WAIT;
            ST_WAIT: if (access_done) state_q <= ST_XFER;
            ST_XFER: begin
               if (last_beat) begin
                  state_q <= ST_IDLE;
               end else begin
                  widx_q <= widx_q + 1'b1;
                  if (mode_q == MODE_SEQ) state_q <= ST_WAIT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bank_start = '0;
      if (state_q == ST_ADDR)
         bank_start = (mode_q == MODE_SEQ) ? WORDS'(1) : '1;
      else if (state_q == ST_XFER && mode_q == MODE_SEQ && !last_beat)
         bank_start = WORDS'(1) << (32'(widx_q) + 1);
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_XFER);
   assign rsp_done  = rsp_valid && last_beat;

   // R2
   accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

   // R2
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R9
   done_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> req_ready);

endmodule

// File: rtl/dram_linefill.sv
module dram_linefill
   import dlf_pkg::*;
#(
   parameter int DW         = 32,
   parameter int LINES      = 16,
   parameter int WORDS      = 4,
   parameter int ACCESS_CYC = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode,
   input  logic                     req_valid,
   input  logic [$clog2(LINES)-1:0] req_addr,
   output logic                     req_ready,
   output logic                     rsp_valid,
   output logic [WORDS*DW-1:0]      rsp_data,
   output logic                     rsp_done
);
   localparam int AW  = $clog2(LINES);
   localparam int WIW = $clog2(WORDS);

   if (WORDS < 2 || (1 << WIW) != WORDS) begin : g_bad_words
      $error("dram_linefill: WORDS must be a power of two, at least 2");
   end
   if (LINES < 2 || ACCESS_CYC < 1 || DW < 1) begin : g_bad_sizes
      $error("dram_linefill: LINES >= 2, ACCESS_CYC >= 1, DW >= 1 required");
   end

   logic [WORDS-1:0] bank_rdy;
   logic [WORDS-1:0] bank_start;
   logic [DW-1:0]    bank_data [WORDS];
   logic [AW-1:0]    line_q;
   logic [WIW-1:0]   widx_q;
   dlf_mode_e        mode_q;

   dlf_sequencer #(.LINES(LINES), .WORDS(WORDS)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .bank_rdy   (bank_rdy),
      .req_ready  (req_ready),
      .bank_start (bank_start),
      .line_q     (line_q),
      .widx_q     (widx_q),
      .mode_q     (mode_q),
      .rsp_valid  (rsp_valid),
      .rsp_done   (rsp_done)
   );

   for (genvar b = 0; b < WORDS; b++) begin : g_bank
      dlf_bank #(
         .DW(DW), .LINES(LINES), .WORDS(WORDS),
         .BANK_ID(b), .ACCESS_CYC(ACCESS_CYC)
      ) bank_i (
         .clk   (clk),
         .rst_n (rst_n),
         .start (bank_start[b]),
         .line  (line_q),
         .rdy   (bank_rdy[b]),
         .data  (bank_data[b])
      );
   end

   for (genvar k = 0; k < WORDS; k++) begin : g_lane
      if (k == 0) begin : g_low
         assign rsp_data[DW-1:0] = !rsp_valid ? '0 :
            (mode_q == MODE_WIDE) ? bank_data[0] : bank_data[widx_q];
      end else begin : g_up
         assign rsp_data[k*DW +: DW] = (rsp_valid && mode_q == MODE_WIDE)
                                       ? bank_data[k] : '0;
      end
   end

   // R7
   done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> rsp_valid);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

endmodule

// File: tb/dram_linefill_tb_top.sv
module dram_linefill_tb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [1:0]   mode;
   logic         req_valid;
   logic [3:0]   req_addr;
   logic         req_ready;
   logic         rsp_valid;
   logic [127:0] rsp_data;
   logic         rsp_done;

   int errs   = 0;
   int checks = 0;

   always #5 clk = ~clk;

   dram_linefill dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
      .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_done(rsp_done)
   );

   // {mode, line, expected cycles to done}
   localparam logic [13:0] VEC [8] = '{
      {2'b00, 4'd3,  8'd65}, {2'b01, 4'd5,  8'd17},
      {2'b10, 4'd9,  8'd20}, {2'b11, 4'd15, 8'd65},
      {2'b10, 4'd0,  8'd20}, {2'b01, 4'd15, 8'd17},
      {2'b00, 4'd0,  8'd65}, {2'b10, 4'd15, 8'd20}
   };

   function automatic logic [31:0] exp_word(input int l, input int w);
      return ((l * 4 + w) * 32'h0101_0101) ^ 32'hA5A5_0000;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // Called at a negedge; returns at the negedge of the done cycle.
   task automatic run_fill(input logic [1:0] m, input int line, input int total,
                           input bit intrude, input bit mchg, input bit chained);
      int waits = 0;
      int beats = 0;
      int done_k = -1;
      int nb;
      bit rdy_bad = 0;
      string ttag;
      nb   = (m == 2'b01) ? 1 : 4;
      ttag = (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R3";
      mode = m; req_addr = 4'(line); req_valid = 1'b1;
      while (!req_ready && waits < 100) begin
         @(negedge clk);
         waits++;
      end
      if (chained) chk(waits == 1, "R9 ready after done", 128'(waits), 128'd1);
      @(posedge clk);
      for (int k = 1; k <= 90; k++) begin
         @(negedge clk);
         if (k == 1 && !intrude) req_valid = 1'b0;
         if (k == 5 && intrude) req_addr = 4'(line ^ 1);
         if (k == 5 && mchg) mode = (m == 2'b01) ? 2'b00 : 2'b01;
         if (req_ready) rdy_bad = 1;
         if (rsp_valid) begin
            int expk;
            logic [127:0] expd;
            expk = (m == 2'b10) ? 17 + beats : 17 + 16 * beats;
            if (m == 2'b01)
               expd = {exp_word(line, 3), exp_word(line, 2),
                       exp_word(line, 1), exp_word(line, 0)};
            else
               expd = {96'b0, exp_word(line, beats)};
            chk(k == expk, {ttag, " beat edge"}, 128'(k), 128'(expk));
            chk(rsp_data == expd, "R6 beat data", rsp_data, expd);
            chk(rsp_done == (beats == nb - 1), "R7 done on last beat",
                128'(rsp_done), 128'(beats == nb - 1));
            beats++;
            if (rsp_done) begin
               done_k = k;
               req_valid = 1'b0;
               break;
            end
         end
      end
      chk(done_k == total, {ttag, " cycles to done"}, 128'(done_k), 128'(total));
      chk(beats == nb, {ttag, " beat count"}, 128'(beats), 128'(nb));
      chk(!rdy_bad, "R2 ready low during fill", 128'(rdy_bad), 128'd0);
      mode = m;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst_n = 1'b0; mode = 2'b00; req_valid = 1'b0; req_addr = '0;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(req_ready && !rsp_valid && !rsp_done && rsp_data == '0,
          "R1 reset state", {rsp_data[123:0], req_ready, rsp_valid, rsp_done},
          128'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !rsp_done && rsp_data == '0,
          "R1 after release", {rsp_data[123:0], req_ready, rsp_valid, rsp_done},
          128'h4);

      for (int i = 0; i < 8; i++) begin
         run_fill(VEC[i][13:12], int'(VEC[i][11:8]), int'(VEC[i][7:0]), 0, 0, 0);
         @(negedge clk);
      end

      // R2: request raised mid-fill is held off and never served
      run_fill(2'b10, 6, 20, 1, 0, 0);
      @(negedge clk);
      chk(req_ready, "R2 idle after held request", 128'(req_ready), 128'd1);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R2 held request not served",
          128'({rsp_valid, req_ready}), 128'b01);

      // R8: mode change during fill has no effect
      run_fill(2'b00, 11, 65, 0, 1, 0);
      @(negedge clk);
      run_fill(2'b01, 2, 17, 0, 1, 0);

      // R9: back-to-back fills, second request waiting at done
      @(negedge clk);
      run_fill(2'b10, 4, 20, 0, 0, 0);
      run_fill(2'b00, 7, 65, 0, 0, 1);

      // R1: reset in the middle of a fill
      @(negedge clk);
      mode = 2'b00; req_addr = 4'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !rsp_done, "R1 reset mid-fill",
          128'({req_ready, rsp_valid, rsp_done}), 128'b100);
      run_fill(2'b11, 8, 65, 0, 0, 0);

      summary();
   end

endmodule